// File: doc/BRIEF.md
# Post-Update Load/Store Address Unit

This unit carries out fixed-point loads and stores that address memory through a base register and then advance that register. The access goes to the base value as it stood before the instruction. The base register is then written back with the base plus a sign-extended immediate. Two immediate shapes are accepted. The first is a 16-bit signed displacement. The second is a 14-bit word-scaled displacement that becomes a multiple of four.

An issuing stage presents one decoded operation with its register indices and operand values. The unit accepts it only while idle and raises a memory request that stays up until the memory acknowledges it. In that acknowledge cycle the unit presents the base-register writeback, together with the formatted load result for loads. Register combinations that the instruction form forbids are refused. These cause a one-cycle flag, and nothing reaches memory or the register file.

The memory bus is XLEN bits wide and big-endian. Bus lane j, at bits [XLEN-1-8j -: 8], holds the byte at address offset j within the aligned bus word, and strobe bit j marks that lane.

Top module: `pu_lsu`

## Requirements
- R1: The memory address of a valid operation equals the old base-register value `op_ra_val`, not the updated one.
- R2: With `op_ds_form`=0, the base writeback `ra_wdata` equals `op_ra_val` plus the 16-bit `op_imm` sign-extended.
- R3: With `op_ds_form`=1, the base writeback equals `op_ra_val` plus `op_imm[13:0]` with two zero bits appended, sign-extended.
- R4: `op_size` encodes 0 as byte, 1 as halfword, 2 as word and 3 as doubleword. A load of 1, 2 or 4 bytes places those bytes in the low bits of `rt_wdata` and clears every higher bit. A doubleword load fills all 64 bits. The first byte is taken from lane `mem_addr[2:0]` rounded down to the access size, and lower addresses are more significant.
- R5: A store drives the low 1, 2, 4 or 8 bytes of `op_rs_val` onto the lanes starting at `mem_addr[2:0]` rounded down to the size, most significant byte at the lowest lane. `mem_strobe` marks exactly those lanes and `mem_we` is 1.
- R6: A load whose base index is 0, or whose base index equals its target index, makes no request and no writeback. `bad_form` is high for exactly the one cycle after the operation is offered.
- R7: A store is refused only when its base index is 0. A store whose base index equals `op_rt_idx` executes normally.
- R8: `mem_req` stays high with `mem_addr` unchanged until `mem_ack`. Writebacks appear only in the acknowledge cycle. A load presents `rt_we` and `ra_we` together, and a store presents only `ra_we`.
- R9: `busy` is high and `op_ready` low from the cycle after acceptance through the acknowledge cycle. Operations offered meanwhile are ignored.
- R10: After reset the unit is idle, with `op_ready`=1 and `busy`, `mem_req`, `bad_form`, `ra_we` and `rt_we` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can accept an operation |
| op_is_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| op_ds_form | input | 1 | 1 = word-scaled 14-bit displacement |
| op_imm | input | 16 | Displacement field |
| op_ra_idx | input | 5 | Base register index |
| op_rt_idx | input | 5 | Load target / store source index |
| op_ra_val | input | 64 | Base register value |
| op_rs_val | input | 64 | Store data value |
| busy | output | 1 | Operation in flight |
| bad_form | output | 1 | One-cycle invalid-form flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 64 | Access address |
| mem_wdata | output | 64 | Write data on big-endian lanes |
| mem_strobe | output | 8 | Byte-lane enables |
| mem_ack | input | 1 | Request completed (read data valid for loads) |
| mem_rdata | input | 64 | Read data |
| ra_we | output | 1 | Base register write enable |
| ra_widx | output | 5 | Base register write index |
| ra_wdata | output | 64 | Updated base value |
| rt_we | output | 1 | Target register write enable |
| rt_widx | output | 5 | Target register write index |
| rt_wdata | output | 64 | Formatted load result |

## Verification
A wrong latched base or offset appears in the acknowledge cycle as a bad `mem_addr` or `ra_wdata`. The address error is already visible in the first request cycle, one clock after acceptance. A lane-offset or size error changes `mem_strobe` and `mem_wdata` during the request, or changes `rt_wdata` in the acknowledge cycle. A wrong state bit shows as a request that does not hold or that repeats, as `busy` that outlasts the acknowledge, or as `bad_form` missing or misplaced in the cycle after the offer.

// File: rtl/pu_lsu_pkg.sv
package pu_lsu_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } lsu_state_e;
endpackage

// File: rtl/pu_lsu_agen.sv
module pu_lsu_agen #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5,
    parameter int IMM_W = 16,
    parameter int DS_W  = 14
) (
    input  logic [XLEN-1:0]  base,
    input  logic [IMM_W-1:0] imm,
    input  logic             ds_form,
    input  logic             is_store,
    input  logic [IDX_W-1:0] ra_idx,
    input  logic [IDX_W-1:0] rt_idx,
    output logic [XLEN-1:0]  next_base,
    output logic             bad_form
);
    localparam int D_PAD  = XLEN - IMM_W;
    localparam int DS_PAD = XLEN - DS_W - 2;

    logic [XLEN-1:0] d_off;
    logic [XLEN-1:0] ds_off;

    // byte displacement and word-scaled displacement, both sign-extended
    assign d_off  = {{D_PAD{imm[IMM_W-1]}}, imm};
    assign ds_off = {{DS_PAD{imm[DS_W-1]}}, imm[DS_W-1:0], 2'b00};

    assign next_base = base + (ds_form ? ds_off : d_off);

    // loads may not update the register they load into
    assign bad_form = (ra_idx == '0) || (!is_store && (ra_idx == rt_idx));
endmodule

// File: rtl/pu_lsu_st_fmt.sv
module pu_lsu_st_fmt
    import pu_lsu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]                src,
    input  acc_size_e                      size,
    input  logic [$clog2(XLEN/8)-1:0]      lane,
    output logic [XLEN-1:0]                bus_data,
    output logic [XLEN/8-1:0]              strobe
);
    localparam int NB = XLEN / 8;

    int              nb_i;
    int              off_i;
    int              sh_i;
    logic [XLEN-1:0] trimmed;

    always_comb begin
        nb_i  = 1 << int'(size);
        off_i = int'(lane) & ~(nb_i - 1);
        sh_i  = NB - off_i - nb_i;
        for (int i = 0; i < NB; i++) begin
            trimmed[8*i +: 8] = (i < nb_i) ? src[8*i +: 8] : 8'h00;
        end
        bus_data = trimmed << (8 * sh_i);
    end

    for (genvar j = 0; j < NB; j++) begin : g_strobe
        assign strobe[j] = (j >= off_i) && (j < off_i + nb_i);
    end
endmodule

// File: rtl/pu_lsu_ld_fmt.sv
module pu_lsu_ld_fmt
    import pu_lsu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]                bus_data,
    input  acc_size_e                      size,
    input  logic [$clog2(XLEN/8)-1:0]      lane,
    output logic [XLEN-1:0]                result
);
    localparam int NB = XLEN / 8;

    int              nb_i;
    int              off_i;
    logic [XLEN-1:0] aligned;

    always_comb begin
        nb_i    = 1 << int'(size);
        off_i   = int'(lane) & ~(nb_i - 1);
        aligned = bus_data >> (8 * (NB - off_i - nb_i));
        for (int i = 0; i < NB; i++) begin
            result[8*i +: 8] = (i < nb_i) ? aligned[8*i +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/pu_lsu.sv
module pu_lsu
    import pu_lsu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IDX_W = 5,
    parameter int IMM_W = 16,
    parameter int DS_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              op_is_store,
    input  logic [1:0]        op_size,
    input  logic              op_ds_form,
    input  logic [IMM_W-1:0]  op_imm,
    input  logic [IDX_W-1:0]  op_ra_idx,
    input  logic [IDX_W-1:0]  op_rt_idx,
    input  logic [XLEN-1:0]   op_ra_val,
    input  logic [XLEN-1:0]   op_rs_val,
    output logic              busy,
    output logic              bad_form,
    output logic              mem_req,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_addr,
    output logic [XLEN-1:0]   mem_wdata,
    output logic [XLEN/8-1:0] mem_strobe,
    input  logic              mem_ack,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              ra_we,
    output logic [IDX_W-1:0]  ra_widx,
    output logic [XLEN-1:0]   ra_wdata,
    output logic              rt_we,
    output logic [IDX_W-1:0]  rt_widx,
    output logic [XLEN-1:0]   rt_wdata
);
    localparam int NB     = XLEN / 8;
    localparam int LANE_W = $clog2(NB);

    typedef struct packed {
        lsu_state_e       state;
        logic             is_store;
        acc_size_e        size;
        logic [XLEN-1:0]  addr;
        logic [XLEN-1:0]  new_base;
        logic [XLEN-1:0]  sdata;
        logic [IDX_W-1:0] ra_idx;
        logic [IDX_W-1:0] rt_idx;
        logic             bad;
    } lsu_regs_t;

    lsu_regs_t       r_d, r_q;
    logic [XLEN-1:0] next_base_c;
    logic            bad_form_c;
    logic            accept_c;
    logic            done_c;

    pu_lsu_agen #(
        .XLEN (XLEN),
        .IDX_W(IDX_W),
        .IMM_W(IMM_W),
        .DS_W (DS_W)
    ) u_agen (
        .base     (op_ra_val),
        .imm      (op_imm),
        .ds_form  (op_ds_form),
        .is_store (op_is_store),
        .ra_idx   (op_ra_idx),
        .rt_idx   (op_rt_idx),
        .next_base(next_base_c),
        .bad_form (bad_form_c)
    );

    assign accept_c = op_valid && (r_q.state == ST_IDLE);
    assign done_c   = (r_q.state == ST_WAIT) && mem_ack;

    always_comb begin
        r_d     = r_q;
        r_d.bad = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (accept_c) begin
                    if (bad_form_c) begin
                        r_d.bad = 1'b1;
                    end else begin
                        r_d.state    = ST_WAIT;
                        r_d.is_store = op_is_store;
                        r_d.size     = acc_size_e'(op_size);
                        r_d.addr     = op_ra_val;
                        r_d.new_base = next_base_c;
                        r_d.sdata    = op_rs_val;
                        r_d.ra_idx   = op_ra_idx;
                        r_d.rt_idx   = op_rt_idx;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_ack) r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    pu_lsu_st_fmt #(.XLEN(XLEN)) u_st_fmt (
        .src     (r_q.sdata),
        .size    (r_q.size),
        .lane    (r_q.addr[LANE_W-1:0]),
        .bus_data(mem_wdata),
        .strobe  (mem_strobe)
    );

    pu_lsu_ld_fmt #(.XLEN(XLEN)) u_ld_fmt (
        .bus_data(mem_rdata),
        .size    (r_q.size),
        .lane    (r_q.addr[LANE_W-1:0]),
        .result  (rt_wdata)
    );

    assign busy     = (r_q.state == ST_WAIT);
    assign op_ready = (r_q.state == ST_IDLE);
    assign bad_form = r_q.bad;
    assign mem_req  = busy;
    assign mem_we   = r_q.is_store;
    assign mem_addr = r_q.addr;

    assign ra_we    = done_c;
    assign ra_widx  = r_q.ra_idx;
    assign ra_wdata = r_q.new_base;
    assign rt_we    = done_c && !r_q.is_store;
    assign rt_widx  = r_q.rt_idx;
endmodule

// File: rtl/pu_lsu_chk.sv
module pu_lsu_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            op_ready,
    input logic            busy,
    input logic            bad_form,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_ack,
    input logic            ra_we,
    input logic            rt_we
);
    p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    p_wb_on_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ra_we |-> mem_req && mem_ack);

    p_rt_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rt_we |-> ra_we && !mem_we);

    p_refuse_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !op_ready);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !busy && !mem_req);

    p_bad_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_form |-> !mem_req && !ra_we && !rt_we);
endmodule

bind pu_lsu pu_lsu_chk #(.XLEN(XLEN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_ready(op_ready),
    .busy    (busy),
    .bad_form(bad_form),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .mem_ack (mem_ack),
    .ra_we   (ra_we),
    .rt_we   (rt_we)
);

// File: tb/pu_lsu_tb.sv
`timescale 1ns/1ps
module pu_lsu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic        op_is_store = 1'b0;
    logic [1:0]  op_size = 2'd0;
    logic        op_ds_form = 1'b0;
    logic [15:0] op_imm = '0;
    logic [4:0]  op_ra_idx = '0;
    logic [4:0]  op_rt_idx = '0;
    logic [63:0] op_ra_val = '0;
    logic [63:0] op_rs_val = '0;
    logic        busy, bad_form, mem_req, mem_we;
    logic [63:0] mem_addr, mem_wdata;
    logic [7:0]  mem_strobe;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        ra_we, rt_we;
    logic [4:0]  ra_widx, rt_widx;
    logic [63:0] ra_wdata, rt_wdata;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [63:0] RD_PAT = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] ST_PAT = 64'h1122_3344_5566_7788;

    always #2.5 clk = ~clk;

    pu_lsu u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_is_store(op_is_store), .op_size(op_size), .op_ds_form(op_ds_form),
        .op_imm(op_imm), .op_ra_idx(op_ra_idx), .op_rt_idx(op_rt_idx),
        .op_ra_val(op_ra_val), .op_rs_val(op_rs_val), .busy(busy),
        .bad_form(bad_form), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_strobe(mem_strobe),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .ra_we(ra_we),
        .ra_widx(ra_widx), .ra_wdata(ra_wdata), .rt_we(rt_we),
        .rt_widx(rt_widx), .rt_wdata(rt_wdata)
    );

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // offer one operation for one cycle; returns at the following negedge
    task automatic offer(input logic st, input logic [1:0] sz, input logic ds,
                         input logic [15:0] imm, input logic [4:0] ra_i,
                         input logic [4:0] rt_i, input logic [63:0] ra_v,
                         input logic [63:0] rs_v);
        op_valid = 1'b1; op_is_store = st; op_size = sz; op_ds_form = ds;
        op_imm = imm; op_ra_idx = ra_i; op_rt_idx = rt_i;
        op_ra_val = ra_v; op_rs_val = rs_v;
        @(negedge clk);
        op_valid = 1'b0;
        #0.5;
    endtask

    // acknowledge the pending request; sample writebacks in the ack cycle
    task automatic ack_now(input logic [63:0] rd);
        mem_ack = 1'b1; mem_rdata = rd;
        #0.5;
    endtask

    task automatic ack_end();
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = '0;
        #0.5;
        chk("R9 idle after ack", {62'd0, busy, mem_req}, 64'd0);
    endtask

    task automatic t_reset();
        chk("R10 reset ready", {63'd0, op_ready}, 64'd1);
        chk("R10 reset busy/req", {62'd0, busy, mem_req}, 64'd0);
        chk("R10 reset bad_form", {63'd0, bad_form}, 64'd0);
        chk("R10 reset writebacks", {62'd0, ra_we, rt_we}, 64'd0);
    endtask

    task automatic t_load(input string tag, input logic [1:0] sz, input logic ds,
                          input logic [15:0] imm, input logic [63:0] base,
                          input logic [63:0] exp_base, input logic [63:0] exp_rt);
        @(negedge clk);
        offer(1'b0, sz, ds, imm, 5'd3, 5'd7, base, '0);
        chk({tag, " R1 load addr"}, mem_addr, base);
        chk({tag, " R8 load req"}, {62'd0, mem_req, mem_we}, 64'd2);
        chk({tag, " R9 busy"}, {62'd0, busy, op_ready}, 64'd2);
        ack_now(RD_PAT);
        chk({tag, " R8 load wb pair"}, {62'd0, ra_we, rt_we}, 64'd3);
        chk({tag, " R8 wb idx"}, {54'd0, ra_widx, rt_widx}, {54'd0, 5'd3, 5'd7});
        chk({tag, " R2/R3 base wb"}, ra_wdata, exp_base);
        chk({tag, " R4 load data"}, rt_wdata, exp_rt);
        ack_end();
    endtask

    task automatic t_store(input string tag, input logic [1:0] sz, input logic ds,
                           input logic [15:0] imm, input logic [4:0] rt_i,
                           input logic [63:0] base, input logic [63:0] exp_base,
                           input logic [63:0] lane_mask, input logic [63:0] exp_w,
                           input logic [7:0] exp_strb);
        @(negedge clk);
        offer(1'b1, sz, ds, imm, 5'd4, rt_i, base, ST_PAT);
        chk({tag, " R1 store addr"}, mem_addr, base);
        chk({tag, " R5 store we"}, {62'd0, mem_req, mem_we}, 64'd3);
        chk({tag, " R5 store lanes"}, mem_wdata & lane_mask, exp_w);
        chk({tag, " R5 store strobe"}, {56'd0, mem_strobe}, {56'd0, exp_strb});
        ack_now('0);
        chk({tag, " R8 store wb only base"}, {62'd0, ra_we, rt_we}, 64'd2);
        chk({tag, " R2/R3 store base wb"}, ra_wdata, exp_base);
        ack_end();
    endtask

    task automatic t_invalid(input string tag, input logic st, input logic [4:0] ra_i,
                             input logic [4:0] rt_i);
        @(negedge clk);
        offer(st, 2'd3, 1'b0, 16'h0008, ra_i, rt_i, 64'h9000, ST_PAT);
        chk({tag, " R6 flag raised"}, {63'd0, bad_form}, 64'd1);
        chk({tag, " R6 no request"}, {62'd0, mem_req, busy}, 64'd0);
        @(negedge clk);
        #0.5;
        chk({tag, " R6 flag one cycle"}, {63'd0, bad_form}, 64'd0);
        chk({tag, " R6 no writeback"}, {61'd0, ra_we, rt_we, mem_req}, 64'd0);
    endtask

    task automatic t_busy_ignore();
        @(negedge clk);
        offer(1'b0, 2'd2, 1'b0, 16'h0010, 5'd5, 5'd6, 64'hA000, '0);
        // second operation offered while busy must be ignored
        op_valid = 1'b1; op_is_store = 1'b1; op_ra_idx = 5'd9; op_ra_val = 64'hB000;
        repeat (3) begin
            @(negedge clk);
            #0.5;
            chk("R9 refuse while busy", {62'd0, op_ready, busy}, 64'd1);
            chk("R8 address held", mem_addr, 64'hA000);
        end
        op_valid = 1'b0;
        ack_now(RD_PAT);
        chk("R9 first op wb", {59'd0, ra_widx}, 64'd5);
        chk("R9 first op base", ra_wdata, 64'hA010);
        chk("R9 first op data", rt_wdata, 64'h0123_4567);
        ack_end();
        @(negedge clk);
        #0.5;
        chk("R9 ignored op never issues", {63'd0, mem_req}, 64'd0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #0.5;
        t_reset();
        rst_n = 1'b1;
        // loads: byte at lane 5, half at lane 2, word at lane 4, double with DS -4
        t_load("lbyte", 2'd0, 1'b0, 16'hFFF0, 64'h1000_0005, 64'h0FFF_FFF5, 64'h0000_0000_0000_00AB);
        t_load("lhalf", 2'd1, 1'b0, 16'h0004, 64'h2002, 64'h2006, 64'h0000_0000_0000_4567);
        t_load("lword", 2'd2, 1'b0, 16'h7FFF, 64'h3004, 64'hB003, 64'h0000_0000_89AB_CDEF);
        t_load("ldbl R3", 2'd3, 1'b1, 16'h3FFF, 64'h4000, 64'h3FFC, RD_PAT);
        // stores
        t_store("sbyte", 2'd0, 1'b0, 16'h0001, 5'd1, 64'h5003, 64'h5004,
                64'h0000_00FF_0000_0000, 64'h0000_0088_0000_0000, 8'h08);
        t_store("shalf", 2'd1, 1'b0, 16'hFFFE, 5'd1, 64'h6006, 64'h6004,
                64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_7788, 8'hC0);
        t_store("sword", 2'd2, 1'b0, 16'h0100, 5'd1, 64'h8000, 64'h8100,
                64'hFFFF_FFFF_0000_0000, 64'h5566_7788_0000_0000, 8'h0F);
        t_store("sdbl R3", 2'd3, 1'b1, 16'h0010, 5'd1, 64'h7000, 64'h7040,
                64'hFFFF_FFFF_FFFF_FFFF, ST_PAT, 8'hFF);
        t_store("R7 same idx", 2'd3, 1'b0, 16'h0008, 5'd4, 64'hC000, 64'hC008,
                64'hFFFF_FFFF_FFFF_FFFF, ST_PAT, 8'hFF);
        // invalid forms
        t_invalid("R6 load ra0", 1'b0, 5'd0, 5'd2);
        t_invalid("R6 load ra=rt", 1'b0, 5'd6, 5'd6);
        t_invalid("R7 store ra0", 1'b1, 5'd0, 5'd2);
        t_busy_ignore();
        finish_run();
    end
endmodule